// File: doc/BRIEF.md
# Slow-Clock Seconds Counter with Trim

This block keeps elapsed whole seconds in a 32-bit count. The count logic runs in a 32.768 kHz oscillator domain, so it keeps running while the rest of the system sleeps. A prescaler in that domain divides the slow clock by a programmable trim value plus one. With a trim of 32767, the count advances once per second.

Software reaches the block through a small register port in the fast bus-clock domain. Trim writes and count writes are posted into the slow domain through toggle handshakes. While a write is in flight, a busy flag per register stays set, and further writes to that register are dropped. The running count comes back through a handshake-captured holding register, so a read never returns a torn value. A bus-domain watchdog reports whether the slow clock is toggling.

Top module: `slowtick_rtc`

## Requirements
- R1: After reset, trim (address 0) reads 0, the read register (address 2) reads 0, and the control word (address 3) has its enable bit (bit 0) and both busy bits (bits 2 and 3) clear.
- R2: While enabled, the count rises by exactly one every trim+1 slow-clock cycles.
- R3: A write to trim sets the trim-busy bit (bit 2 of address 3) from the next bus cycle. Trim then reads back the written value. The bit clears once the value has reached the slow domain. A write to address 1 likewise sets the count-busy bit (bit 3).
- R4: A write to trim or to the count-set register (address 1) is ignored while the matching busy bit is set.
- R5: A write to address 1 loads the count, which then reads back through address 2. The prescaler phase restarts, so the first increment comes one full trim period after the load.
- R6: Bit 0 of address 3 is a read/write enable. While it is 0 the count holds its value.
- R7: Bit 1 of address 3 reads 1 while slow-clock edges arrive. It reads 0 after the slow clock has been still for a fixed number of bus cycles, and 1 again once edges return.
- R8: The count wraps from 0xFFFFFFFF to 0.
- R9: Values seen through address 2 are coherent: successive distinct reads differ by exactly one while counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, bus domain |
| slow_clk | input | 1 | 32.768 kHz oscillator clock |
| slow_rst | input | 1 | Synchronous active-high reset, slow domain |
| bus_wr | input | 1 | Write strobe, one bus cycle per write |
| bus_addr | input | 2 | Register select: 0 trim, 1 count set, 2 count read, 3 control/status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register |

## Verification
The count is driven with a short trim (20 slow cycles per tick), and ten ticks are timed against the slow-clock edges. This separates a divide by trim+1 from a divide by trim or by trim+2. A longer trim, with a load issued while counting, times the first tick after the load; this tells a restarted phase from a carried-over one. Back-to-back writes to trim and to the count-set register show whether a write made while busy is dropped. A preset just below the top of the range shows the wrap. Stopping and restarting the slow clock exercises the presence flag in both directions.

// File: rtl/tyc_pkg.sv
package tyc_pkg;

    localparam int BUS_W = 32;

    typedef enum logic [1:0] {
        SEL_TRIM  = 2'd0,
        SEL_SET   = 2'd1,
        SEL_READ  = 2'd2,
        SEL_CTRL  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [BUS_W-5:0] rsvd;
        logic             set_busy;
        logic             trim_busy;
        logic             clk_ok;
        logic             enable;
    } ctl_stat_t;

    function automatic logic rose(input logic cur, input logic prev);
        return cur & ~prev;
    endfunction

endpackage

// File: rtl/tyc_sync.sv
module tyc_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/tyc_xfer.sv
module tyc_xfer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_i,
    input  logic [W-1:0] data_i,
    output logic         pending_o,
    output logic [W-1:0] held_o,
    input  logic         sclk,
    input  logic         srst,
    output logic         load_o
);
    logic req_t, ack_t, ack_b, req_s;

    tyc_sync #(.W(1)) u_ack_sync (.clk(clk), .rst(rst), .d(ack_t), .q(ack_b));
    tyc_sync #(.W(1)) u_req_sync (.clk(sclk), .rst(srst), .d(req_t), .q(req_s));

    assign pending_o = req_t ^ ack_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_t  <= 1'b0;
            held_o <= '0;
        end else if (wr_i && !pending_o) begin
            req_t  <= ~req_t;
            held_o <= data_i;
        end
    end

    assign load_o = req_s ^ ack_t;

    always_ff @(posedge sclk) begin
        if (srst) ack_t <= 1'b0;
        else      ack_t <= req_s;
    end

    assert_wr_sets_busy_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !pending_o) |=> pending_o);

    assert_busy_wr_dropped_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_i && pending_o) |=> $stable(held_o));

    assert_load_single_R3: assert property (@(posedge sclk) disable iff (srst)
        load_o |=> !load_o);
endmodule

// File: rtl/tyc_snap.sv
module tyc_snap #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] hold_o,
    input  logic         sclk,
    input  logic         srst,
    input  logic [W-1:0] val_i
);
    logic         rq_t, ak_t, ak_b, rq_s;
    logic [W-1:0] snap;

    tyc_sync #(.W(1)) u_ak_sync (.clk(clk), .rst(rst), .d(ak_t), .q(ak_b));
    tyc_sync #(.W(1)) u_rq_sync (.clk(sclk), .rst(srst), .d(rq_t), .q(rq_s));

    always_ff @(posedge clk) begin
        if (rst) begin
            rq_t   <= 1'b0;
            hold_o <= '0;
        end else if (ak_b == rq_t) begin
            hold_o <= snap;
            rq_t   <= ~rq_t;
        end
    end

    always_ff @(posedge sclk) begin
        if (srst) begin
            ak_t <= 1'b0;
            snap <= '0;
        end else if (rq_s != ak_t) begin
            snap <= val_i;
            ak_t <= rq_s;
        end
    end
endmodule

// File: rtl/tyc_core.sv
module tyc_core #(
    parameter int CNT_W  = 32,
    parameter int TRIM_W = 16
) (
    input  logic              sclk,
    input  logic              srst,
    input  logic              en_i,
    input  logic              trim_ld_i,
    input  logic [TRIM_W-1:0] trim_d_i,
    input  logic              cnt_ld_i,
    input  logic [CNT_W-1:0]  cnt_d_i,
    output logic [CNT_W-1:0]  count_o
);
    logic [TRIM_W-1:0] trim_q;
    logic [TRIM_W-1:0] phase;

    always_ff @(posedge sclk) begin
        if (srst) trim_q <= '0;
        else if (trim_ld_i) trim_q <= trim_d_i;
    end

    always_ff @(posedge sclk) begin
        if (srst) begin
            phase   <= '0;
            count_o <= '0;
        end else if (cnt_ld_i) begin
            phase   <= '0;
            count_o <= cnt_d_i;
        end else if (en_i) begin
            if (phase >= trim_q) begin
                phase   <= '0;
                count_o <= count_o + 1'b1;
            end else begin
                phase <= phase + 1'b1;
            end
        end
    end

    assert_step_by_one_R2: assert property (@(posedge sclk) disable iff (srst)
        !cnt_ld_i |=> (count_o == $past(count_o) || count_o == $past(count_o) + 1'b1));

    assert_hold_when_off_R6: assert property (@(posedge sclk) disable iff (srst)
        (!en_i && !cnt_ld_i) |=> $stable(count_o));
endmodule

// File: rtl/slowtick_rtc.sv
module slowtick_rtc
    import tyc_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int TRIM_W   = 16,
    parameter int WD_LIMIT = 8192
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slow_clk,
    input  logic             slow_rst,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata
);
    localparam int WD_W = $clog2(WD_LIMIT + 1);
    localparam logic [WD_W-1:0] WD_MAX = WD_W'(WD_LIMIT);

    reg_sel_e sel;
    assign sel = reg_sel_e'(bus_addr);

    logic wr_trim, wr_set, wr_ctrl;
    assign wr_trim = bus_wr && (sel == SEL_TRIM);
    assign wr_set  = bus_wr && (sel == SEL_SET);
    assign wr_ctrl = bus_wr && (sel == SEL_CTRL);

    // control bit
    logic enable_q;
    always_ff @(posedge clk) begin
        if (rst)          enable_q <= 1'b0;
        else if (wr_ctrl) enable_q <= bus_wdata[0];
    end

    // posted writes
    logic              trim_busy, trim_ld;
    logic [TRIM_W-1:0] trim_held;
    logic              set_busy, set_ld;
    logic [CNT_W-1:0]  set_held;

    tyc_xfer #(.W(TRIM_W)) u_trim_xfer (
        .clk(clk), .rst(rst), .wr_i(wr_trim), .data_i(bus_wdata[TRIM_W-1:0]),
        .pending_o(trim_busy), .held_o(trim_held),
        .sclk(slow_clk), .srst(slow_rst), .load_o(trim_ld)
    );

    tyc_xfer #(.W(CNT_W)) u_set_xfer (
        .clk(clk), .rst(rst), .wr_i(wr_set), .data_i(bus_wdata[CNT_W-1:0]),
        .pending_o(set_busy), .held_o(set_held),
        .sclk(slow_clk), .srst(slow_rst), .load_o(set_ld)
    );

    // slow domain
    logic             en_s;
    logic [CNT_W-1:0] count_s;

    tyc_sync #(.W(1)) u_en_sync (.clk(slow_clk), .rst(slow_rst), .d(enable_q), .q(en_s));

    tyc_core #(.CNT_W(CNT_W), .TRIM_W(TRIM_W)) u_core (
        .sclk(slow_clk), .srst(slow_rst), .en_i(en_s),
        .trim_ld_i(trim_ld), .trim_d_i(trim_held),
        .cnt_ld_i(set_ld), .cnt_d_i(set_held),
        .count_o(count_s)
    );

    // coherent readback
    logic [CNT_W-1:0] count_b;
    tyc_snap #(.W(CNT_W)) u_snap (
        .clk(clk), .rst(rst), .hold_o(count_b),
        .sclk(slow_clk), .srst(slow_rst), .val_i(count_s)
    );

    // slow clock presence watchdog
    logic            sc_q, sc_prev, sc_edge, clk_ok;
    logic [WD_W-1:0] wd;

    tyc_sync #(.W(1)) u_sc_sync (.clk(clk), .rst(rst), .d(slow_clk), .q(sc_q));
    assign sc_edge = rose(sc_q, sc_prev);

    always_ff @(posedge clk) begin
        if (rst) begin
            sc_prev <= 1'b0;
            wd      <= '0;
            clk_ok  <= 1'b0;
        end else begin
            sc_prev <= sc_q;
            if (sc_edge) begin
                wd     <= '0;
                clk_ok <= 1'b1;
            end else if (wd == WD_MAX) begin
                clk_ok <= 1'b0;
            end else begin
                wd <= wd + 1'b1;
            end
        end
    end

    // read mux
    ctl_stat_t stat;
    always_comb begin
        stat           = '0;
        stat.enable    = enable_q;
        stat.clk_ok    = clk_ok;
        stat.trim_busy = trim_busy;
        stat.set_busy  = set_busy;
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_TRIM: bus_rdata[TRIM_W-1:0] = trim_held;
            SEL_READ: bus_rdata[CNT_W-1:0]  = count_b;
            SEL_CTRL: bus_rdata             = stat;
            default:  bus_rdata             = '0;
        endcase
    end

    assert_edge_marks_ok_R7: assert property (@(posedge clk) disable iff (rst)
        sc_edge |=> clk_ok);

    assert_ok_drop_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(clk_ok) |-> !$past(sc_edge));

    assert_enable_follows_wr_R6: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> (enable_q == $past(bus_wdata[0])));
endmodule

// File: tb/slowtick_rtc_bench.sv
`timescale 1ns/1ps
module slowtick_rtc_bench;
    logic        clk = 1'b0, rst = 1'b1, sclk = 1'b0, srst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    bit slow_run = 1'b1;
    bit done = 1'b0;
    int total = 0, bad = 0, sedges = 0;

    typedef struct {
        logic [31:0] exp;
        logic [31:0] mask;
        string       tag;
    } item_t;
    item_t sb[$];

    slowtick_rtc #(.CNT_W(32), .TRIM_W(16), .WD_LIMIT(64)) u_slowtick_rtc (
        .clk(clk), .rst(rst), .slow_clk(sclk), .slow_rst(srst),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    always #4 clk = ~clk;
    always begin
        #40;
        if (slow_run) sclk = ~sclk;
    end
    always @(posedge sclk) sedges++;

    // scoreboard monitor
    always @(negedge clk) begin
        item_t it;
        if (sb.size() > 0) begin
            it = sb.pop_front();
            total++;
            if ((bus_rdata & it.mask) !== it.exp) begin
                bad++;
                $display("FAIL %s: actual=%h expected=%h", it.tag, bus_rdata & it.mask, it.exp);
            end
        end
    end

    task automatic probe(input logic [1:0] a, input logic [31:0] e, input logic [31:0] m, input string tag);
        @(posedge clk); #1 bus_addr = a;
        sb.push_back('{e & m, m, tag});
        @(negedge clk); #1;
    endtask

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] e);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, e);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(posedge clk); #1 bus_addr = a;
        @(negedge clk); v = bus_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #1 bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1 bus_wr = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        logic [31:0] v;
        for (int i = 0; i < 3000; i++) begin
            rd(2'd3, v);
            if (v[3:2] == 2'b00) return;
        end
        check(1'b0, tag, v, 32'h0);
    endtask

    task automatic wait_change(input logic [31:0] old, output logic [31:0] nv, output int e, input string tag);
        logic [31:0] v;
        for (int i = 0; i < 20000; i++) begin
            rd(2'd2, v);
            if (v != old) begin
                nv = v; e = sedges; return;
            end
        end
        nv = old; e = sedges;
        check(1'b0, tag, old, old + 1);
    endtask

    task automatic wait_value(input logic [31:0] want, output int e, input string tag);
        logic [31:0] v;
        for (int i = 0; i < 20000; i++) begin
            rd(2'd2, v);
            if (v == want) begin
                e = sedges; return;
            end
        end
        e = sedges;
        check(1'b0, tag, v, want);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, prev, nv;
        int e0, e1, ew;
        repeat (4) @(posedge sclk);
        @(posedge clk); #1 rst = 1'b0;
        @(posedge sclk); #1 srst = 1'b0;

        // R1 reset state
        probe(2'd0, 32'h0, 32'hFFFF_FFFF, "R1 trim after reset");
        probe(2'd2, 32'h0, 32'hFFFF_FFFF, "R1 count after reset");
        probe(2'd3, 32'h0, 32'h0000_000D, "R1 control after reset");

        // R7 clock present
        repeat (40) @(posedge clk);
        probe(2'd3, 32'h2, 32'h2, "R7 clock detected");

        // R3 trim write handshake
        wr(2'd0, 32'd19);
        probe(2'd3, 32'h4, 32'h4, "R3 trim busy set");
        probe(2'd0, 32'd19, 32'hFFFF_FFFF, "R3 trim readback");
        wait_idle("R3 trim busy clears");
        probe(2'd3, 32'h0, 32'h4, "R3 trim busy clear");

        // R4 trim write while busy is dropped
        wr(2'd0, 32'd23);
        wr(2'd0, 32'd5);
        wait_idle("R4 idle");
        probe(2'd0, 32'd23, 32'hFFFF_FFFF, "R4 trim write while busy");
        wr(2'd0, 32'd19);
        wait_idle("R3 idle");

        // R3/R4/R5 count set while disabled
        wr(2'd1, 32'd100);
        probe(2'd3, 32'h8, 32'h8, "R3 set busy set");
        wr(2'd1, 32'd200);
        wait_idle("R4 idle set");
        repeat (100) @(posedge clk);
        probe(2'd2, 32'd100, 32'hFFFF_FFFF, "R4 set write while busy");
        repeat (300) @(posedge clk);
        probe(2'd2, 32'd100, 32'hFFFF_FFFF, "R6 hold while disabled");
        wr(2'd1, 32'h1234);
        wait_idle("R5 idle");
        repeat (100) @(posedge clk);
        probe(2'd2, 32'h1234, 32'hFFFF_FFFF, "R5 loaded value");

        // R2 / R9 rate with trim 19
        wr(2'd3, 32'h1);
        probe(2'd3, 32'h1, 32'h1, "R6 enable readback");
        rd(2'd2, v);
        wait_change(v, prev, e0, "R2 first tick");
        for (int k = 0; k < 10; k++) begin
            wait_change(prev, nv, e1, "R2 tick");
            check(nv == prev + 1, "R9 step of one", nv, prev + 1);
            prev = nv;
        end
        check((e1 - e0) >= 195 && (e1 - e0) <= 205, "R2 ten periods of 20", e1 - e0, 200);

        // R5 phase restart with trim 49
        wr(2'd0, 32'd49);
        wait_idle("R5 trim idle");
        ew = sedges;
        wr(2'd1, 32'd500);
        wait_value(32'd501, e1, "R5 first tick after load");
        check((e1 - ew) >= 51 && (e1 - ew) <= 60, "R5 first tick one period after load", e1 - ew, 50);

        // R8 wrap
        wr(2'd0, 32'd9);
        wait_idle("R8 trim idle");
        wr(2'd1, 32'hFFFF_FFFE);
        wait_idle("R8 set idle");
        wait_value(32'hFFFF_FFFF, e1, "R8 reach top");
        wait_change(32'hFFFF_FFFF, nv, e1, "R8 wrap");
        check(nv == 32'h0, "R8 wrap to zero", nv, 32'h0);

        // R6 disable holds
        wr(2'd3, 32'h0);
        repeat (150) @(posedge clk);
        rd(2'd2, v);
        repeat (400) @(posedge clk);
        probe(2'd2, v, 32'hFFFF_FFFF, "R6 hold after disable");

        // R7 clock loss and return
        slow_run = 1'b0;
        repeat (150) @(posedge clk);
        probe(2'd3, 32'h0, 32'h2, "R7 clock lost");
        slow_run = 1'b1;
        repeat (60) @(posedge clk);
        probe(2'd3, 32'h2, 32'h2, "R7 clock back");

        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule